// File: doc/BRIEF.md
# Main-Processor Address Decoder with Tightly Coupled Windows

This block turns one memory access of the main processor into a region choice and a byte offset local to that region. The access comes in as an address and a width (byte, halfword or word). Two software-configured windows onto tightly coupled memory are checked first. The instruction window always starts at address zero. The data window can be placed at any base. When neither window claims the access, the top address byte picks a region from a fixed map. That map covers main RAM, shared work RAM, I/O, palette, video RAM, object attribute memory, cartridge ROM, cartridge SRAM and boot ROM.

The decode itself is combinational and is followed by one register stage, so a result appears one clock after its request. Each result is exactly one of three things: a one-hot region select with its offset, a flag meaning the read returns all ones, or a flag meaning the address is unmapped. In the same cycle as the registered result, a small lane former takes the bytes the selected memory returns and builds the read value least-significant byte first. It overrides that value with all ones or with zero for the two flagged cases.

Top module: `cpu_addr_decoder`

## Requirements
- R1: Before any decode, the address is aligned to the access width. Width code 0 is byte, 1 is halfword and 2 is word. A halfword clears address bit 0 and a word clears bits 1:0. Offsets are formed from the aligned address.
- R2: The instruction window hits when `iwin_en` is 1 and the aligned address is below `iwin_size`. A hit sets `region_sel` bit 0, and `local_off` is aligned address bits 14:0.
- R3: The data window is considered only when the instruction window misses. It hits when `dwin_en` is 1 and `dwin_base` <= address < `dwin_base` + `dwin_size`. A hit sets `region_sel` bit 1, and `local_off` is (address − base) bits 13:0.
- R4: A window hit takes precedence over the fixed map, even when the address also lies in a fixed region.
- R5: With no window hit, address bits 31:24 choose the region. The table below gives each top byte, the `region_sel` bit it sets, and the `local_off` value. Main RAM, palette and OAM keep only the low address bits shown. The other regions carry address bits 23:0.

  | Top byte | Region | `region_sel` bit | `local_off` |
  |---|---|---|---|
  | 0x02 | main RAM | 2 | bits 21:0 |
  | 0x03 | shared work RAM | 3 | bits 23:0 |
  | 0x04 | I/O | 4 | bits 23:0 |
  | 0x05 | palette | 5 | bits 10:0 |
  | 0x06 | video RAM | 6 | bits 23:0 |
  | 0x07 | OAM | 7 | bits 10:0 |
  | 0x08 or 0x09 | cartridge ROM | 8 | bits 24:0 |
  | 0x0A | cartridge SRAM | 9 | bits 23:0 |

- R6: A cartridge ROM access whose 25-bit offset is at or above `rom_size` selects nothing. It raises `const_ones`, and `rd_data` is all ones across the access width.
- R7: Top byte 0xFF selects boot ROM, `region_sel` bit 10, only when (address AND 0xFFFF8000) equals 0xFFFF0000. `local_off` is then bits 15:0. Any other 0xFF address is unmapped.
- R8: An address that no window and no region claims selects nothing and raises `unmapped`. Its `rd_data` is zero. Whenever nothing is selected, `local_off` is zero.
- R9: For a selected region, `rd_data` is built least-significant byte first from `mem_rdata`, whose byte i sits at bits 8i+7:8i. A byte access returns bits 7:0 and a halfword returns bits 15:0. All higher bits are zero.
- R10: A result appears on the outputs one clock after `req_valid`. During reset, and in any cycle without a result, `out_valid`, `region_sel`, `local_off`, `const_ones` and `unmapped` are all zero.
- R11: Every valid result carries exactly one of three outcomes: a single select bit, `const_ones`, or `unmapped`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_addr | input | 32 | Access address |
| req_size | input | 2 | Access width: 0 byte, 1 halfword, 2 word |
| iwin_en | input | 1 | Instruction window enable |
| iwin_size | input | 32 | Instruction window size in bytes |
| dwin_en | input | 1 | Data window enable |
| dwin_base | input | 32 | Data window base address |
| dwin_size | input | 32 | Data window size in bytes |
| rom_size | input | 32 | Populated cartridge ROM size in bytes |
| mem_rdata | input | 32 | Bytes returned by the selected memory, lowest address in bits 7:0 |
| out_valid | output | 1 | Registered result valid |
| region_sel | output | 11 | One-hot region select |
| local_off | output | 32 | Byte offset within the selected region |
| const_ones | output | 1 | Read returns all ones (ROM beyond its size) |
| unmapped | output | 1 | No region claims the address |
| rd_data | output | 32 | Formed read value |

## Verification
Two decoders can claim the same address in one cycle. One case is a window hit together with a fixed-region match. Another is the instruction and data windows overlapping each other. The bench provokes both on purpose. In one configuration the data window is relocated onto main RAM, and in another onto the object attribute memory with a range that straddles a boundary. A third configuration overlaps the two windows across the address range near zero. Addresses on both sides of every window edge and every region edge are driven at all three access widths. Each result is judged against a priority model computed in the bench: the instruction window first, then the data window, then the fixed map. The bench also confirms that exactly one outcome is reported for every access.

// File: rtl/cpu_dec_pkg.sv
// Shared constants for the main-processor address decoder.
// Assumes a 32-bit byte address and the region bit order listed below.
package cpu_dec_pkg;
    localparam int ADDR_W      = 32;
    localparam int NUM_REGIONS = 11;

    // One-hot bit position of each region in the select vector
    localparam int RG_IWIN  = 0;
    localparam int RG_DWIN  = 1;
    localparam int RG_MAIN  = 2;
    localparam int RG_SHWR  = 3;
    localparam int RG_IO    = 4;
    localparam int RG_PAL   = 5;
    localparam int RG_VRAM  = 6;
    localparam int RG_OAM   = 7;
    localparam int RG_CROM  = 8;
    localparam int RG_CSRAM = 9;
    localparam int RG_BOOT  = 10;

    // Access width codes
    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2
    } acc_size_t;

    // Boot ROM qualification
    localparam logic [ADDR_W-1:0] BOOT_QUAL_MASK = 32'hFFFF_8000;
    localparam logic [ADDR_W-1:0] BOOT_QUAL_BASE = 32'hFFFF_0000;
endpackage

// File: rtl/addr_aligner.sv
// Clears the low address bits implied by the access width.
// Assumes width codes from cpu_dec_pkg; the reserved code 3 aligns as a word.
module addr_aligner
    import cpu_dec_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr_in,
    input  logic [1:0]    size_in,
    output logic [AW-1:0] addr_out
);
    // Build the alignment mask from the access width and apply it
    always_comb begin
        addr_out = addr_in;
        case (size_in)
            ACC_BYTE: addr_out = addr_in;
            ACC_HALF: addr_out[0] = 1'b0;
            default:  addr_out[1:0] = 2'b00;
        endcase
    end
endmodule

// File: rtl/tcm_window_check.sv
// Tests one tightly coupled memory window: base <= addr < base + size.
// The range test uses (addr - base) < size, so base + size never overflows.
// Offset keeps OFF_W bits of (addr - base).
module tcm_window_check #(
    parameter int AW    = 32,
    parameter int OFF_W = 15
) (
    input  logic          win_en,
    input  logic [AW-1:0] win_base,
    input  logic [AW-1:0] win_size,
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [AW-1:0] off
);
    logic [AW-1:0] rel;

    // Relative address and in-range test
    always_comb begin
        rel = addr - win_base;
        hit = win_en && (addr >= win_base) && (rel < win_size);
    end

    // Truncate the relative address to the window's offset width
    always_comb begin
        off = '0;
        off[OFF_W-1:0] = rel[OFF_W-1:0];
    end
endmodule

// File: rtl/fixed_region_map.sv
// Decodes the top address byte into the fixed region map.
// Handles the cartridge ROM size limit and boot ROM qualification.
// Assumes an aligned address. At most one output class is active:
// a select bit, rom_ones or miss.
module fixed_region_map
    import cpu_dec_pkg::*;
#(
    parameter int AW         = ADDR_W,
    parameter int NR         = NUM_REGIONS,
    parameter int MAIN_OFF_W = 22,
    parameter int PAL_OFF_W  = 11,
    parameter int OAM_OFF_W  = 11,
    parameter int ROM_OFF_W  = 25,
    parameter int BOOT_OFF_W = 16,
    parameter int WIDE_OFF_W = 24
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] rom_size,
    output logic [NR-1:0] sel,
    output logic [AW-1:0] off,
    output logic          rom_ones,
    output logic          miss
);
    localparam int TOP_LSB = AW - 8;

    logic [AW-1:0] rom_off;
    logic          boot_ok;

    // Cartridge ROM offset and boot ROM qualification terms
    always_comb begin
        rom_off = '0;
        rom_off[ROM_OFF_W-1:0] = addr[ROM_OFF_W-1:0];
        boot_ok = (addr & BOOT_QUAL_MASK) == BOOT_QUAL_BASE;
    end

    // Top-byte case decode with per-region offset masking
    always_comb begin
        sel      = '0;
        off      = '0;
        rom_ones = 1'b0;
        miss     = 1'b0;
        case (addr[AW-1:TOP_LSB])
            8'h02: begin
                sel[RG_MAIN] = 1'b1;
                off[MAIN_OFF_W-1:0] = addr[MAIN_OFF_W-1:0];
            end
            8'h03: begin
                sel[RG_SHWR] = 1'b1;
                off[WIDE_OFF_W-1:0] = addr[WIDE_OFF_W-1:0];
            end
            8'h04: begin
                sel[RG_IO] = 1'b1;
                off[WIDE_OFF_W-1:0] = addr[WIDE_OFF_W-1:0];
            end
            8'h05: begin
                sel[RG_PAL] = 1'b1;
                off[PAL_OFF_W-1:0] = addr[PAL_OFF_W-1:0];
            end
            8'h06: begin
                sel[RG_VRAM] = 1'b1;
                off[WIDE_OFF_W-1:0] = addr[WIDE_OFF_W-1:0];
            end
            8'h07: begin
                sel[RG_OAM] = 1'b1;
                off[OAM_OFF_W-1:0] = addr[OAM_OFF_W-1:0];
            end
            8'h08, 8'h09: begin
                if (rom_off < rom_size) begin
                    sel[RG_CROM] = 1'b1;
                    off = rom_off;
                end else begin
                    rom_ones = 1'b1;
                end
            end
            8'h0A: begin
                sel[RG_CSRAM] = 1'b1;
                off[WIDE_OFF_W-1:0] = addr[WIDE_OFF_W-1:0];
            end
            8'hFF: begin
                if (boot_ok) begin
                    sel[RG_BOOT] = 1'b1;
                    off[BOOT_OFF_W-1:0] = addr[BOOT_OFF_W-1:0];
                end else begin
                    miss = 1'b1;
                end
            end
            default: miss = 1'b1;
        endcase
    end
endmodule

// File: rtl/read_lane_former.sv
// Builds the read value least-significant byte first from memory bytes.
// Forces all ones (in the access width) for out-of-range ROM and zero for
// unmapped addresses. Assumes byte i of mem_bytes is at bits 8i+7:8i.
module read_lane_former
    import cpu_dec_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [1:0]    size,
    input  logic          force_ones,
    input  logic          force_zero,
    input  logic [DW-1:0] mem_bytes,
    output logic [DW-1:0] rd_value
);
    localparam int NBYTES = DW / 8;

    logic [NBYTES-1:0] lane_keep;
    logic [DW-1:0]     lane_mask;

    // Decide how many byte lanes the access width keeps
    always_comb begin
        case (size)
            ACC_BYTE: lane_keep = NBYTES'(1);
            ACC_HALF: lane_keep = NBYTES'(3);
            default:  lane_keep = '1;
        endcase
    end

    // Expand the lane enables into a bit mask
    genvar gi;
    generate
        for (gi = 0; gi < NBYTES; gi++) begin : g_lane
            assign lane_mask[gi*8 +: 8] = {8{lane_keep[gi]}};
        end
    endgenerate

    // Pick the value source and apply the lane mask
    always_comb begin
        if (force_zero)
            rd_value = '0;
        else if (force_ones)
            rd_value = lane_mask;
        else
            rd_value = mem_bytes & lane_mask;
    end
endmodule

// File: rtl/cpu_addr_decoder.sv
// Main-processor address decoder. Priority is: instruction window, then
// data window, then the fixed map. One register stage gives a result one
// clock after its request. Synchronous active-low reset clears the result
// registers. The read value is formed from the registered result and the
// live memory bytes.
module cpu_addr_decoder
    import cpu_dec_pkg::*;
#(
    parameter int AW          = ADDR_W,
    parameter int NR          = NUM_REGIONS,
    parameter int IWIN_OFF_W  = 15,
    parameter int DWIN_OFF_W  = 14,
    parameter int NUM_WINDOWS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [31:0]   req_addr,
    input  logic [1:0]    req_size,
    input  logic          iwin_en,
    input  logic [31:0]   iwin_size,
    input  logic          dwin_en,
    input  logic [31:0]   dwin_base,
    input  logic [31:0]   dwin_size,
    input  logic [31:0]   rom_size,
    input  logic [31:0]   mem_rdata,
    output logic          out_valid,
    output logic [10:0]   region_sel,
    output logic [31:0]   local_off,
    output logic          const_ones,
    output logic          unmapped,
    output logic [31:0]   rd_data
);
    logic [AW-1:0] addr_al;

    logic [NUM_WINDOWS-1:0] win_en_v;
    logic [AW-1:0]          win_base_v [NUM_WINDOWS];
    logic [AW-1:0]          win_size_v [NUM_WINDOWS];
    logic [NUM_WINDOWS-1:0] win_hit;
    logic [AW-1:0]          win_off [NUM_WINDOWS];

    logic [NR-1:0] fix_sel;
    logic [AW-1:0] fix_off;
    logic          fix_ones;
    logic          fix_miss;

    logic [NR-1:0] sel_n;
    logic [AW-1:0] off_n;
    logic          ones_n;
    logic          miss_n;
    logic [1:0]    size_q;

    addr_aligner #(.AW(AW)) i_align (
        .addr_in  (req_addr),
        .size_in  (req_size),
        .addr_out (addr_al)
    );

    // Window configuration vectors: window 0 is fixed at base zero
    always_comb begin
        win_en_v[0]   = iwin_en;
        win_base_v[0] = '0;
        win_size_v[0] = iwin_size;
        win_en_v[1]   = dwin_en;
        win_base_v[1] = dwin_base;
        win_size_v[1] = dwin_size;
    end

    genvar gw;
    generate
        for (gw = 0; gw < NUM_WINDOWS; gw++) begin : g_win
            localparam int WOFF = (gw == 0) ? IWIN_OFF_W : DWIN_OFF_W;
            tcm_window_check #(.AW(AW), .OFF_W(WOFF)) i_win (
                .win_en   (win_en_v[gw]),
                .win_base (win_base_v[gw]),
                .win_size (win_size_v[gw]),
                .addr     (addr_al),
                .hit      (win_hit[gw]),
                .off      (win_off[gw])
            );
        end
    endgenerate

    fixed_region_map #(.AW(AW), .NR(NR)) i_fixed (
        .addr     (addr_al),
        .rom_size (rom_size),
        .sel      (fix_sel),
        .off      (fix_off),
        .rom_ones (fix_ones),
        .miss     (fix_miss)
    );

    // Priority merge: instruction window, data window, then fixed map
    always_comb begin
        sel_n  = '0;
        off_n  = '0;
        ones_n = 1'b0;
        miss_n = 1'b0;
        if (win_hit[0]) begin
            sel_n[RG_IWIN] = 1'b1;
            off_n = win_off[0];
        end else if (win_hit[1]) begin
            sel_n[RG_DWIN] = 1'b1;
            off_n = win_off[1];
        end else begin
            sel_n  = fix_sel;
            off_n  = fix_off;
            ones_n = fix_ones;
            miss_n = fix_miss;
        end
    end

    // Result register: capture on request, clear otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            region_sel <= '0;
            local_off  <= '0;
            const_ones <= 1'b0;
            unmapped   <= 1'b0;
            size_q     <= 2'b00;
        end else begin
            out_valid  <= req_valid;
            region_sel <= req_valid ? sel_n  : '0;
            local_off  <= req_valid ? off_n  : '0;
            const_ones <= req_valid ? ones_n : 1'b0;
            unmapped   <= req_valid ? miss_n : 1'b0;
            size_q     <= req_size;
        end
    end

    read_lane_former #(.DW(32)) i_lanes (
        .size       (size_q),
        .force_ones (const_ones),
        .force_zero (unmapped),
        .mem_bytes  (mem_rdata),
        .rd_value   (rd_data)
    );

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($onehot0(region_sel) &&
                       $countones({|region_sel, const_ones, unmapped}) == 1)); // R11

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(req_valid))); // R10

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (region_sel == '0 && local_off == '0 && !const_ones && !unmapped)); // R10

    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && region_sel[RG_IWIN] && size_q == ACC_WORD) |-> (local_off[1:0] == 2'b00)); // R1

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (rd_data == '0 && local_off == '0)); // R8

    AST_ROM_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (const_ones && size_q == ACC_WORD) |-> (rd_data == '1)); // R6

    AST_IWIN_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && win_hit[0]) |=> (region_sel[RG_IWIN] && !region_sel[RG_DWIN])); // R4
endmodule

// File: tb/test_cpu_addr_decoder.sv
// Sweep bench: four window configurations x fourteen top bytes x eight low
// patterns x three access widths, each compared against a priority model.
module test_cpu_addr_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        iwin_en = 1'b0;
    logic [31:0] iwin_size = '0;
    logic        dwin_en = 1'b0;
    logic [31:0] dwin_base = '0;
    logic [31:0] dwin_size = '0;
    logic [31:0] rom_size = 32'h0100_0000;
    logic [31:0] mem_rdata = 32'hA1B2_C3D4;
    logic        out_valid;
    logic [10:0] region_sel;
    logic [31:0] local_off;
    logic        const_ones;
    logic        unmapped;
    logic [31:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cpu_addr_decoder i_cpu_addr_decoder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .iwin_en(iwin_en), .iwin_size(iwin_size),
        .dwin_en(dwin_en), .dwin_base(dwin_base), .dwin_size(dwin_size),
        .rom_size(rom_size), .mem_rdata(mem_rdata), .out_valid(out_valid),
        .region_sel(region_sel), .local_off(local_off), .const_ones(const_ones),
        .unmapped(unmapped), .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp,
                         input logic [31:0] addr);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%08h actual=%08h expected=%08h", tag, addr, act, exp);
        end
    endtask

    // Priority model built from the requirements
    task automatic model(input logic [31:0] addr, input logic [1:0] sz,
                         output int idx, output logic [31:0] off,
                         output bit ones, output bit unm, output string tag);
        logic [31:0] a;
        a = addr & ~((sz == 2) ? 32'd3 : (sz == 1) ? 32'd1 : 32'd0);
        idx = -1; off = 0; ones = 0; unm = 0; tag = "R5";
        if (iwin_en && a < iwin_size) begin
            idx = 0; off = a & 32'h7FFF; tag = "R2";
        end else if (dwin_en && a >= dwin_base && (a - dwin_base) < dwin_size) begin
            idx = 1; off = (a - dwin_base) & 32'h3FFF; tag = "R3";
        end else begin
            case (a[31:24])
                8'h02: begin idx = 2; off = a & 32'h3F_FFFF; end
                8'h03: begin idx = 3; off = a & 32'hFF_FFFF; end
                8'h04: begin idx = 4; off = a & 32'hFF_FFFF; end
                8'h05: begin idx = 5; off = a & 32'h7FF; end
                8'h06: begin idx = 6; off = a & 32'hFF_FFFF; end
                8'h07: begin idx = 7; off = a & 32'h7FF; end
                8'h08, 8'h09: begin
                    if ((a & 32'h1FF_FFFF) < rom_size) begin idx = 8; off = a & 32'h1FF_FFFF; end
                    else begin ones = 1; tag = "R6"; end
                end
                8'h0A: begin idx = 9; off = a & 32'hFF_FFFF; end
                8'hFF: begin
                    tag = "R7";
                    if ((a & 32'hFFFF_8000) == 32'hFFFF_0000) begin idx = 10; off = a & 32'hFFFF; end
                    else unm = 1;
                end
                default: begin unm = 1; tag = "R8"; end
            endcase
        end
        // R4: a window hit over an address the fixed map would also claim
        if (idx <= 1 && idx >= 0 && a[31:24] inside {8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07})
            tag = "R4";
    endtask

    function automatic logic [31:0] top_of(input int i);
        case (i)
            0: return 32'h00; 1: return 32'h01; 2: return 32'h02; 3: return 32'h03;
            4: return 32'h04; 5: return 32'h05; 6: return 32'h06; 7: return 32'h07;
            8: return 32'h08; 9: return 32'h09; 10: return 32'h0A; 11: return 32'h0B;
            12: return 32'hFE; default: return 32'hFF;
        endcase
    endfunction

    function automatic logic [31:0] low_of(input int i);
        case (i)
            0: return 32'h00_0000; 1: return 32'h00_0003; 2: return 32'h00_7FF2;
            3: return 32'h00_7FFF; 4: return 32'h00_8001; 5: return 32'h00_BFFE;
            6: return 32'hFF_0001; default: return 32'hFF_FFFF;
        endcase
    endfunction

    task automatic set_cfg(input int c);
        case (c)
            0: begin iwin_en = 0; iwin_size = 32'h8000; dwin_en = 0; dwin_base = 32'h0; dwin_size = 32'h4000; end
            1: begin iwin_en = 1; iwin_size = 32'h8000; dwin_en = 1; dwin_base = 32'h0200_0000; dwin_size = 32'h4000; end
            2: begin iwin_en = 1; iwin_size = 32'h8000; dwin_en = 1; dwin_base = 32'h0000_4000; dwin_size = 32'h8000; end
            default: begin iwin_en = 0; iwin_size = 32'h8000; dwin_en = 1; dwin_base = 32'h0700_7FF0; dwin_size = 32'h20; end
        endcase
    endtask

    // Drive one access, wait for the registered result, compare every output
    task automatic run_one(input logic [31:0] addr, input logic [1:0] sz);
        int idx; logic [31:0] off; bit ones; bit unm; string tag;
        logic [31:0] lmask, exp_rd, exp_sel;
        model(addr, sz, idx, off, ones, unm, tag);
        req_addr = addr; req_size = sz; req_valid = 1'b1;
        mem_rdata = addr ^ 32'h5A3C_96E1;
        @(negedge clk);
        lmask = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
        exp_sel = (idx >= 0) ? (32'd1 << idx) : 32'd0;
        exp_rd = unm ? 32'd0 : ones ? lmask : (mem_rdata & lmask);
        check({"R10 out_valid ", tag}, {31'd0, out_valid}, 32'd1, addr);
        check({tag, " region_sel"}, {21'd0, region_sel}, exp_sel, addr);
        check((sz != 0 && (addr & 3) != 0) ? {"R1 offset ", tag} : {tag, " offset"},
              local_off, off, addr);
        check("R6 const_ones", {31'd0, const_ones}, {31'd0, ones}, addr);
        check("R8 unmapped", {31'd0, unmapped}, {31'd0, unm}, addr);
        check("R11 single outcome", 32'($countones({|region_sel, const_ones, unmapped})), 32'd1, addr);
        check(unm ? "R8 rd_data" : ones ? "R6 rd_data" : "R9 rd_data", rd_data, exp_rd, addr);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R10 watchdog expired actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 reset out_valid", {31'd0, out_valid}, 32'd0, 32'd0);
        check("R10 reset region_sel", {21'd0, region_sel}, 32'd0, 32'd0);
        check("R10 reset flags", {30'd0, const_ones, unmapped}, 32'd0, 32'd0);
        rst_n = 1'b1;
        for (int c = 0; c < 4; c++) begin
            set_cfg(c);
            for (int t = 0; t < 14; t++)
                for (int l = 0; l < 8; l++)
                    for (int s = 0; s < 3; s++)
                        run_one((top_of(t) << 24) | low_of(l), 2'(s));
        end
        // Boot ROM edges and ROM size edge (R7, R6)
        set_cfg(0);
        run_one(32'hFFFF_7FFC, 2'd2);
        run_one(32'hFFFF_8000, 2'd2);
        run_one(32'hFFFE_FFFF, 2'd0);
        run_one(32'h08FF_FFFF, 2'd0);
        run_one(32'h0900_0000, 2'd1);
        // Idle cycle after traffic: outputs clear (R10)
        req_valid = 1'b0;
        @(negedge clk);
        check("R10 idle out_valid", {31'd0, out_valid}, 32'd0, 32'd0);
        check("R10 idle region_sel", {21'd0, region_sel}, 32'd0, 32'd0);
        check("R10 idle local_off", local_off, 32'd0, 32'd0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule